// File: doc/BRIEF.md
# Latched Current-Mode PWM Cycle Logic

This block is the gate-drive logic of a fixed-frequency current-mode switching controller, expressed in system-clock ticks. An external oscillator gives a one-tick start pulse at the beginning of each switching period. That pulse restarts an internal timing ramp and, when the cycle may switch, turns the gate on. The pulse then ends at the first of four events: a current-comparator trip, an overcurrent trip, the duty ceiling, or the end of the ramp. After that the gate stays off until the next start pulse.

The current comparators often chatter just after the switch turns on. For this reason both trip inputs are ignored for a fixed blanking window, sized in ticks from a time in nanoseconds. A duty code is compared with the ramp position to set the longest on-time. A code below the bottom of the ramp blocks the gate outright, and this block is not latched. A half-duty mode lets only every other period switch. An overcurrent trip removes the gate in the same cycle and produces a one-tick fault pulse for the fault logic outside this block.

Top module: `cm_pwm_cycle`

## Requirements
- R1: Once a pulse has ended within a period, gate_o stays low until the next start pulse, even if the trip inputs fall again. At most one on-pulse occurs per period.
- R2: When a start pulse is sampled at a clock edge and the cycle may switch, gate_o is high from that edge onward.
- R3: cs_trip_i and oc_trip_i are ignored during the first BLANK_TICKS ticks of every pulse. BLANK_TICKS = ceil(BLANK_NS / CLK_NS), which is 10 by default. As a result, no trip can end a pulse shorter than BLANK_TICKS+1 ticks.
- R4: A cs_trip_i sampled at the k-th edge after the start edge, outside blanking, gives a pulse exactly k ticks wide.
- R5: The duty limit is L = clamp(duty_i − DUTY_BASE, 0, RAMP_TICKS), with DUTY_BASE = 32 and RAMP_TICKS = 64 by default. With no trip, the pulse lasts L ticks. After the ramp ends, the gate stays low until the next start.
- R6: When duty_i < DUTY_BASE, gate_o goes low in the same cycle. This inhibit is not latched: raising the code again allows a pulse at the next start.
- R7: When half_i is high, only the 1st, 3rd, 5th… start pulses after half mode or enable is taken up produce a pulse.
- R8: An oc_trip_i outside blanking forces gate_o low in the same cycle and ends the pulse. fault_o is then high for exactly one tick, starting at the next edge.
- R9: When en_i is low, gate_o is low. The pulse latch and the half-duty toggle are cleared, so the first start after re-enable produces a pulse.
- R10: During reset, gate_o and fault_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low forces the gate off and clears state |
| start_i | input | 1 | One-tick oscillator pulse that starts a period |
| cs_trip_i | input | 1 | Current comparator trip |
| oc_trip_i | input | 1 | Overcurrent comparator trip |
| duty_i | input | DUTY_W | Duty ceiling code, compared with the ramp |
| half_i | input | 1 | Half-frequency, half-duty mode select |
| gate_o | output | 1 | Gate drive |
| fault_o | output | 1 | One-tick overcurrent fault report |

## Verification
The bench sets trips at positions inside, at the edge of, and past the blanking window. This separates a blanked trip from one that takes effect, and it places the shortest trip-ended pulse exactly. Duty codes below, at, inside and above the ramp span set each limit branch of the clamp apart from the others. A trip placed after the duty limit shows which of the two ends the pulse first. Sequences in half mode, across an enable drop, and with the duty code falling in the middle of a pulse show the alternation, the toggle clear, and the fact that the inhibit is not latched.

// File: rtl/cm_pwm_pkg.sv
package cm_pwm_pkg;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/cm_pwm_ramp.sv
module cm_pwm_ramp #(
  parameter int unsigned RAMP_TICKS = 64,
  parameter int unsigned DUTY_W     = 8,
  parameter int unsigned DUTY_BASE  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              win_next_o,
  output logic              inhibit_o
);
  localparam int unsigned RW = $clog2(RAMP_TICKS + 1);
  localparam int unsigned CW = (DUTY_W > RW) ? DUTY_W : RW;

  logic [RW-1:0] ramp_q, ramp_d;
  logic [CW-1:0] diff, lim;

  always_comb begin
    if (start_i)                        ramp_d = '0;
    else if (ramp_q < RW'(RAMP_TICKS))  ramp_d = ramp_q + 1'b1;
    else                                ramp_d = ramp_q;
  end

  // duty ceiling: ticks allowed since start, clamped to ramp span
  always_comb begin
    diff = CW'(duty_i) - CW'(DUTY_BASE);
    if (duty_i <= DUTY_W'(DUTY_BASE))   lim = '0;
    else if (diff > CW'(RAMP_TICKS))    lim = CW'(RAMP_TICKS);
    else                                lim = diff;
  end

  assign win_next_o = CW'(ramp_d) < lim;
  assign inhibit_o  = duty_i < DUTY_W'(DUTY_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ramp_q <= RW'(RAMP_TICKS);
    else         ramp_q <= ramp_d;
  end

  AST_RAMP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_q <= RW'(RAMP_TICKS)); // R5
  AST_RAMP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ramp_q == '0); // R5

endmodule

// File: rtl/cm_pwm_blank.sv
module cm_pwm_blank #(
  parameter int unsigned BLANK_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic on_i,
  output logic blanked_o
);
  localparam int unsigned BW = $clog2(BLANK_TICKS + 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= BW'(BLANK_TICKS);
    else if (restart_i)                            cnt_q <= '0;
    else if (on_i && (cnt_q < BW'(BLANK_TICKS)))   cnt_q <= cnt_q + 1'b1;
  end

  assign blanked_o = cnt_q < BW'(BLANK_TICKS);

  AST_BLANK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= BW'(BLANK_TICKS)); // R3

endmodule

// File: rtl/cm_pwm_toggle.sv
module cm_pwm_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic half_i,
  input  logic start_i,
  output logic allow_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tog_q <= 1'b0;
    else if (!en_i || !half_i) tog_q <= 1'b0;
    else if (start_i)          tog_q <= ~tog_q;
  end

  assign allow_o = ~half_i | ~tog_q;

  AST_HALF_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && half_i && start_i) |=> (tog_q != $past(tog_q))); // R7

endmodule

// File: rtl/cm_pwm_cycle.sv
module cm_pwm_cycle
  import cm_pwm_pkg::*;
#(
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned BLANK_NS   = 100,
  parameter int unsigned RAMP_TICKS = 64,
  parameter int unsigned DUTY_W     = 8,
  parameter int unsigned DUTY_BASE  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              cs_trip_i,
  input  logic              oc_trip_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              half_i,
  output logic              gate_o,
  output logic              fault_o
);
  localparam int unsigned BLANK_TICKS = ceil_div(BLANK_NS, CLK_NS);

  logic on_q, on_d, fault_q;
  logic win_next, inhibit, blanked, allow;
  logic cs_eff, oc_eff;

  cm_pwm_ramp #(
    .RAMP_TICKS(RAMP_TICKS),
    .DUTY_W    (DUTY_W),
    .DUTY_BASE (DUTY_BASE)
  ) i_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .duty_i    (duty_i),
    .win_next_o(win_next),
    .inhibit_o (inhibit)
  );

  cm_pwm_blank #(
    .BLANK_TICKS(BLANK_TICKS)
  ) i_blank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(start_i),
    .on_i     (on_q),
    .blanked_o(blanked)
  );

  cm_pwm_toggle i_toggle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .half_i (half_i),
    .start_i(start_i),
    .allow_o(allow)
  );

  assign cs_eff = cs_trip_i & ~blanked;
  assign oc_eff = oc_trip_i & ~blanked;

  // set by start only, cleared by trip or ceiling: one pulse per period
  always_comb begin
    if (!en_i)        on_d = 1'b0;
    else if (start_i) on_d = allow & win_next;
    else              on_d = on_q & ~cs_eff & ~oc_eff & win_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      on_q    <= on_d;
      fault_q <= en_i & on_q & oc_eff;
    end
  end

  assign gate_o  = en_i & on_q & ~oc_eff & ~inhibit;
  assign fault_o = fault_q;

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(on_q) |-> $past(start_i)); // R1
  AST_BLANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_q && blanked && en_i && !start_i && win_next) |=> on_q); // R3
  AST_OC_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_q && oc_trip_i && !blanked && en_i && !start_i) |=> (!on_q && fault_o)); // R8
  AST_FAULT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o); // R8
  AST_EN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!on_q && !fault_o)); // R9

endmodule

// File: tb/test_cm_pwm_cycle.sv
module test_cm_pwm_cycle;
  localparam int BLANK = 10;
  localparam int RAMP  = 64;
  localparam int BASE  = 32;
  localparam int PER   = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0, start_i = 1'b0, cs_i = 1'b0, oc_i = 1'b0, half_i = 1'b0;
  logic [7:0] duty_i = 8'd0;
  logic       gate_o, fault_o;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R10";

  // reference model state
  int m_t = RAMP;
  int m_age = 0;
  bit m_act = 0;
  bit m_odd = 0;
  bit m_fault = 0;

  always #5 clk = ~clk;

  cm_pwm_cycle i_cm_pwm_cycle (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en_i),
    .start_i  (start_i),
    .cs_trip_i(cs_i),
    .oc_trip_i(oc_i),
    .duty_i   (duty_i),
    .half_i   (half_i),
    .gate_o   (gate_o),
    .fault_o  (fault_o)
  );

  function automatic int duty_limit(input int d);
    if (d <= BASE) return 0;
    if (d - BASE > RAMP) return RAMP;
    return d - BASE;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = RAMP; m_age = 0; m_act = 0; m_odd = 0; m_fault = 0;
    end else begin
      int  lim;
      bit  blk;
      lim = duty_limit(int'(duty_i));
      blk = m_age < BLANK;
      m_fault = en_i && m_act && oc_i && !blk;
      if (start_i) m_t = 0;
      else if (m_t < RAMP) m_t = m_t + 1;
      if (!en_i) begin
        m_act = 0; m_odd = 0;
      end else if (start_i) begin
        m_act = (!half_i || !m_odd) && (lim > 0);
        m_odd = half_i ? !m_odd : 1'b0;
        m_age = 0;
      end else if (m_act) begin
        if ((cs_i || oc_i) && !blk) m_act = 0;
        else if (m_t >= lim)        m_act = 0;
        m_age = m_age + 1;
      end
    end
  end

  // per-tick comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit exp_g;
      exp_g = en_i && m_act && !(oc_i && m_age >= BLANK) && !(int'(duty_i) < BASE);
      checks++;
      if (gate_o !== exp_g) begin
        errors++;
        $display("FAIL %s: gate_o=%0b expected %0b at %0t", cur_req, gate_o, exp_g, $time);
      end
      checks++;
      if (fault_o !== m_fault) begin
        errors++;
        $display("FAIL %s: fault_o=%0b expected %0b at %0t", cur_req, fault_o, m_fault, $time);
      end
    end
  end

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one period, entered just before a rising edge; cs/oc held two ticks from their offset
  task automatic run_period(input int duty, input int duty2, input int drop_at,
                            input bit half, input bit en, input int cs_at, input int oc_at,
                            input int exp_w, input int exp_f, input string tag);
    int w = 0;
    int f = 0;
    bit first = 0;
    cur_req = tag;
    en_i = en; half_i = half; duty_i = 8'(duty);
    start_i = 1'b1; cs_i = 1'b0; oc_i = 1'b0;
    for (int k = 0; k < PER; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      cs_i = (cs_at > 0) && ((k + 1 == cs_at) || (k + 1 == cs_at + 1));
      oc_i = (oc_at > 0) && ((k + 1 == oc_at) || (k + 1 == oc_at + 1));
      if (drop_at > 0 && k + 1 >= drop_at) duty_i = 8'(duty2);
      #3;
      if (gate_o) w++;
      if (fault_o) f++;
      if (k == 0) first = gate_o;
    end
    check_int({tag, " width"}, w, exp_w);
    check_int({tag, " fault count"}, f, exp_f);
    check_int({"R2 first tick (", tag, ")"}, int'(first), int'(exp_w > 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_int("R10 gate in reset", int'(gate_o), 0);
    check_int("R10 fault in reset", int'(fault_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    // R5 duty ceiling branches
    run_period(120, 120, 0, 0, 1, 0, 0, RAMP, 0, "R5 above span");
    run_period(52, 52, 0, 0, 1, 0, 0, 20, 0, "R5 mid span");
    run_period(BASE, BASE, 0, 0, 1, 0, 0, 0, 0, "R5 at base");
    // R4 / R1 trip after blanking, released trip does not restart
    run_period(96, 96, 0, 0, 1, 25, 0, 25, 0, "R4 R1 trip at 25");
    run_period(96, 96, 0, 0, 1, BLANK + 1, 0, BLANK + 1, 0, "R3 R4 first unblanked");
    run_period(96, 96, 0, 0, 1, 5, 0, RAMP, 0, "R3 cs blanked");
    run_period(40, 40, 0, 0, 1, 15, 0, 8, 0, "R5 ceiling before trip");
    // R8 overcurrent
    run_period(96, 96, 0, 0, 1, 0, 30, 29, 1, "R8 oc trip");
    run_period(96, 96, 0, 0, 1, 0, 4, RAMP, 0, "R3 oc blanked");
    // R6 inhibit, not latched
    run_period(20, 20, 0, 0, 1, 0, 0, 0, 0, "R6 inhibit");
    run_period(96, 96, 0, 0, 1, 0, 0, RAMP, 0, "R6 release");
    run_period(96, 10, 30, 0, 1, 0, 0, 29, 0, "R6 drop mid pulse");
    // R7 half mode alternation
    run_period(96, 96, 0, 1, 1, 0, 0, RAMP, 0, "R7 half first");
    run_period(96, 96, 0, 1, 1, 0, 0, 0, 0, "R7 half second");
    run_period(96, 96, 0, 1, 1, 0, 0, RAMP, 0, "R7 half third");
    // R9 enable clears toggle
    run_period(96, 96, 0, 1, 0, 0, 0, 0, 0, "R9 disabled");
    run_period(96, 96, 0, 1, 1, 0, 0, RAMP, 0, "R9 reenable");
    run_period(96, 96, 0, 0, 1, 0, 0, RAMP, 0, "R1 normal again");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL %s: watchdog cycles=20000 expected fewer", cur_req);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule